// File: doc/BRIEF.md
# Key-Locked Flash Program and Erase Controller

This block is the register front end of a small on-chip flash array. A word-wide bus (address, write enable, write data, combinational read data) reaches six control registers and a window onto the array itself. The top address bit selects between the two. The array is a behavioural halfword memory inside the block, so the controller needs no outside model.

After reset the controller refuses every change to the array. Software must first write two fixed key words, in order, to the key register. It can then program one halfword at a time, erase one page, or erase every unprotected page. A cycle counter models how long each operation takes. While an operation runs, a busy flag is raised. When it finishes, an end-of-operation flag is set. Failed attempts raise sticky error flags, and software clears these by writing ones.

A second key register takes the same two words and grants option write permission, which software can drop again. Setting the relock bit closes the controller until a fresh key sequence arrives. A wrong key word closes it for good until reset.

Top module: `flash_ctl`

## Requirements
- R1: After reset, the control register (offset 0x10) reads 0x80, meaning lock bit 7 is set. The status register (offset 0x0C) reads 0, and every halfword of the array reads 0xFFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) unlocks the controller, so the control register's bit 7 reads 0.
- R3: Any other value written to the key register while locked holds the controller locked until reset, even if the correct pair follows.
- R4: While locked, writes to the control register, the address register (offset 0x14) and the flash window are ignored.
- R5: Writing 1 to control bit 7 relocks the controller and clears the command bits. After that, writes are ignored until the two keys are written again.
- R6: With program bit 0 set, a write to a flash address programs the halfword in write-data bits 15:0. Status bit 0 (busy) is high for exactly PROG_CYCLES cycles. After that the new value reads back and status bit 5 (end of operation) is set.
- R7: Programming a halfword that is not 0xFFFF with nonzero data sets status bit 2 and leaves the location unchanged. Writing 0x0000 over any value is allowed.
- R8: With page-erase bit 1 set and a byte offset in the address register, writing control bit 6 (start) erases that page to 0xFFFF. Busy lasts ERASE_CYCLES cycles, other pages are unchanged, and bit 6 reads 1 until busy falls.
- R9: With mass-erase bit 2 set, start erases every unprotected page to 0xFFFF.
- R10: Start with no erase command bit already stored has no effect: no busy and no flag.
- R11: A program or page erase aimed at a page marked in WP_MASK sets status bit 4. It does not raise busy and leaves the array unchanged.
- R12: Status bits 2, 4 and 5 clear when 1 is written to them. Writing 0 to them leaves them set.
- R13: Control bit 8 (option write enable) is set only by writing the two keys to the option key register (offset 0x08) while unlocked. Writing 1 to it directly has no effect, and writing 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; top bit selects the flash window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench builds the controller with a 256-byte array of four 64-byte pages, PROG_CYCLES of 5, ERASE_CYCLES of 12, and page 2 write-protected. These sizes let the bench sweep the whole array after each erase and compare it against its model. The short busy windows let it count busy exactly. Because one page is protected, the write-protect flag can be reached both by program and by erase, and mass erase must leave that page alone.

// File: rtl/flc_pkg.sv
package flc_pkg;
    localparam int OFS_ACR  = 'h00;
    localparam int OFS_KEY  = 'h04;
    localparam int OFS_OKEY = 'h08;
    localparam int OFS_SR   = 'h0C;
    localparam int OFS_CR   = 'h10;
    localparam int OFS_AR   = 'h14;

    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

    // control bit positions
    localparam int CB_PG     = 0;
    localparam int CB_PER    = 1;
    localparam int CB_MER    = 2;
    localparam int CB_OPTPG  = 4;
    localparam int CB_OPTER  = 5;
    localparam int CB_STRT   = 6;
    localparam int CB_LOCK   = 7;
    localparam int CB_OPTWRE = 8;

    // status bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_PGERR = 2;
    localparam int SB_WPERR = 4;
    localparam int SB_EOP   = 5;

    typedef enum logic [1:0] {
        KS_SHUT,
        KS_HALF,
        KS_OPEN,
        KS_JAMMED
    } key_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_PAGE,
        OP_MASS
    } op_e;

    typedef struct packed {
        logic pg;
        logic per;
        logic mer;
        logic optpg;
        logic opter;
        logic strt;
    } ctrl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/flc_key_seq.sv
module flc_key_seq
    import flc_pkg::*;
#(
    parameter bit JAM_ON_ERR = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        key_we,
    input  logic [31:0] key_val,
    input  logic        relock,
    output logic        open
);
    key_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_SHUT;
        end else if (!enable) begin
            state_q <= KS_SHUT;
        end else if (relock && state_q == KS_OPEN) begin
            state_q <= KS_SHUT;
        end else if (key_we) begin
            case (state_q)
                KS_SHUT: state_q <= (key_val == KEY_FIRST) ? KS_HALF
                                  : (JAM_ON_ERR ? KS_JAMMED : KS_SHUT);
                KS_HALF: state_q <= (key_val == KEY_SECOND) ? KS_OPEN
                                  : (JAM_ON_ERR ? KS_JAMMED : KS_SHUT);
                default: state_q <= state_q;
            endcase
        end
    end

    assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/flc_busy_timer.sv
module flc_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start && cnt_q == '0) begin
            cnt_q <= load;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flc_array.sv
module flc_array #(
    parameter int HW_DEPTH  = 2048,
    parameter int PAGE_HW   = 512,
    parameter int NUM_PAGES = 4,
    parameter int IDX_W     = 11,
    parameter int PG_W      = 2,
    parameter logic [NUM_PAGES-1:0] WP_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [15:0]      wr_data,
    input  logic             er_en,
    input  logic             er_mass,
    input  logic [PG_W-1:0]  er_page
);
    localparam int PAGE_SH = $clog2(PAGE_HW);

    logic [15:0] mem [HW_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HW_DEPTH; i++) mem[i] <= 16'hFFFF;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end else if (er_en) begin
            for (int i = 0; i < HW_DEPTH; i++) begin
                if (er_mass) begin
                    if (!WP_MASK[i >> PAGE_SH]) mem[i] <= 16'hFFFF;
                end else if ((i >> PAGE_SH) == int'(er_page)) begin
                    mem[i] <= 16'hFFFF;
                end
            end
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
    import flc_pkg::*;
#(
    parameter int ARRAY_BYTES  = 4096,
    parameter int PAGE_BYTES   = 1024,
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 2000,
    parameter logic [ARRAY_BYTES/PAGE_BYTES-1:0] WP_MASK = '0,
    localparam int ADDR_W = $clog2(ARRAY_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int HW_DEPTH  = ARRAY_BYTES / 2;
    localparam int PAGE_HW   = PAGE_BYTES / 2;
    localparam int NUM_PAGES = ARRAY_BYTES / PAGE_BYTES;
    localparam int PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int IDX_W     = $clog2(HW_DEPTH);
    localparam int CNT_W     = $clog2(max2(PROG_CYCLES, ERASE_CYCLES) + 1);

    // decode
    logic              is_flash;
    logic [ADDR_W-2:0] ofs;
    logic              reg_we, key_we, okey_we, sr_we, cr_we, ar_we, fl_we;
    logic              relock, opt_drop;
    logic              unlocked, opt_open, busy, op_done;

    ctrl_t             ctrl_q;
    logic [31:0]       ar_q;
    logic              pgerr_q, wperr_q, eop_q;
    op_e               op_q;
    logic [IDX_W-1:0]  pend_idx;
    logic [15:0]       pend_data;
    logic [PG_W-1:0]   pend_page;

    logic [IDX_W-1:0]  fl_idx;
    logic [15:0]       arr_rd;
    logic [PG_W-1:0]   fl_page, ar_page;
    logic              prog_wp, prog_bad, prog_go;
    logic              strt_req, erase_wp, erase_go;
    logic [CNT_W-1:0]  load_val;

    assign is_flash = bus_addr[ADDR_W-1];
    assign ofs      = bus_addr[ADDR_W-2:0];
    assign fl_idx   = bus_addr[IDX_W:1];

    assign reg_we  = bus_we && !is_flash;
    assign key_we  = reg_we && (ofs == (ADDR_W-1)'(OFS_KEY));
    assign okey_we = reg_we && (ofs == (ADDR_W-1)'(OFS_OKEY));
    assign sr_we   = reg_we && (ofs == (ADDR_W-1)'(OFS_SR));
    assign cr_we   = reg_we && (ofs == (ADDR_W-1)'(OFS_CR)) && unlocked && !busy;
    assign ar_we   = reg_we && (ofs == (ADDR_W-1)'(OFS_AR)) && unlocked && !busy;
    assign fl_we   = bus_we && is_flash && unlocked && !busy && ctrl_q.pg;

    assign relock   = cr_we && bus_wdata[CB_LOCK];
    assign opt_drop = cr_we && !bus_wdata[CB_OPTWRE];

    generate
        if (NUM_PAGES > 1) begin : g_paged
            assign fl_page = fl_idx[IDX_W-1 -: PG_W];
            assign ar_page = ar_q[IDX_W -: PG_W];
        end else begin : g_single
            assign fl_page = '0;
            assign ar_page = '0;
        end
    endgenerate

    // command qualification
    assign prog_wp  = WP_MASK[fl_page];
    assign prog_bad = (arr_rd != 16'hFFFF) && (bus_wdata[15:0] != 16'h0000);
    assign prog_go  = fl_we && !prog_wp && !prog_bad;

    assign strt_req = cr_we && !relock && bus_wdata[CB_STRT] && (ctrl_q.per || ctrl_q.mer);
    assign erase_wp = !ctrl_q.mer && WP_MASK[ar_page];
    assign erase_go = strt_req && !erase_wp;

    assign load_val = prog_go ? CNT_W'(PROG_CYCLES) : CNT_W'(ERASE_CYCLES);

    flc_key_seq #(.JAM_ON_ERR(1'b1)) u_main_key (
        .clk     (clk),
        .rst     (rst),
        .enable  (1'b1),
        .key_we  (key_we),
        .key_val (bus_wdata),
        .relock  (relock),
        .open    (unlocked)
    );

    flc_key_seq #(.JAM_ON_ERR(1'b0)) u_opt_key (
        .clk     (clk),
        .rst     (rst),
        .enable  (unlocked && !relock),
        .key_we  (okey_we),
        .key_val (bus_wdata),
        .relock  (opt_drop),
        .open    (opt_open)
    );

    flc_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (prog_go || erase_go),
        .load  (load_val),
        .busy  (busy),
        .done  (op_done)
    );

    flc_array #(
        .HW_DEPTH  (HW_DEPTH),
        .PAGE_HW   (PAGE_HW),
        .NUM_PAGES (NUM_PAGES),
        .IDX_W     (IDX_W),
        .PG_W      (PG_W),
        .WP_MASK   (WP_MASK)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (fl_idx),
        .rd_data (arr_rd),
        .wr_en   (op_done && op_q == OP_PROG),
        .wr_idx  (pend_idx),
        .wr_data (pend_data),
        .er_en   (op_done && (op_q == OP_PAGE || op_q == OP_MASS)),
        .er_mass (op_q == OP_MASS),
        .er_page (pend_page)
    );

    // pending operation
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= OP_NONE;
            pend_idx  <= '0;
            pend_data <= '0;
            pend_page <= '0;
        end else if (prog_go) begin
            op_q      <= OP_PROG;
            pend_idx  <= fl_idx;
            pend_data <= bus_wdata[15:0];
        end else if (erase_go) begin
            op_q      <= ctrl_q.mer ? OP_MASS : OP_PAGE;
            pend_page <= ar_page;
        end else if (op_done) begin
            op_q      <= OP_NONE;
        end
    end

    // control and address registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ar_q   <= '0;
        end else begin
            if (relock) begin
                ctrl_q <= '0;
            end else if (cr_we) begin
                ctrl_q.pg  <= bus_wdata[CB_PG];
                ctrl_q.per <= bus_wdata[CB_PER];
                ctrl_q.mer <= bus_wdata[CB_MER];
                if (opt_open && bus_wdata[CB_OPTWRE]) begin
                    ctrl_q.optpg <= bus_wdata[CB_OPTPG];
                    ctrl_q.opter <= bus_wdata[CB_OPTER];
                end else begin
                    ctrl_q.optpg <= 1'b0;
                    ctrl_q.opter <= 1'b0;
                end
                ctrl_q.strt <= erase_go;
            end else if (op_done) begin
                ctrl_q.strt <= 1'b0;
            end
            if (ar_we) ar_q <= bus_wdata;
        end
    end

    // status flags: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pgerr_q <= 1'b0;
            wperr_q <= 1'b0;
            eop_q   <= 1'b0;
        end else begin
            if (fl_we && !prog_wp && prog_bad)                 pgerr_q <= 1'b1;
            else if (sr_we && bus_wdata[SB_PGERR])             pgerr_q <= 1'b0;
            if ((fl_we && prog_wp) || (strt_req && erase_wp))  wperr_q <= 1'b1;
            else if (sr_we && bus_wdata[SB_WPERR])             wperr_q <= 1'b0;
            if (op_done)                                       eop_q   <= 1'b1;
            else if (sr_we && bus_wdata[SB_EOP])               eop_q   <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (is_flash) begin
            bus_rdata[15:0] = arr_rd;
        end else if (ofs == (ADDR_W-1)'(OFS_SR)) begin
            bus_rdata[SB_BUSY]  = busy;
            bus_rdata[SB_PGERR] = pgerr_q;
            bus_rdata[SB_WPERR] = wperr_q;
            bus_rdata[SB_EOP]   = eop_q;
        end else if (ofs == (ADDR_W-1)'(OFS_CR)) begin
            bus_rdata[CB_PG]     = ctrl_q.pg;
            bus_rdata[CB_PER]    = ctrl_q.per;
            bus_rdata[CB_MER]    = ctrl_q.mer;
            bus_rdata[CB_OPTPG]  = ctrl_q.optpg;
            bus_rdata[CB_OPTER]  = ctrl_q.opter;
            bus_rdata[CB_STRT]   = ctrl_q.strt;
            bus_rdata[CB_LOCK]   = !unlocked;
            bus_rdata[CB_OPTWRE] = opt_open;
        end else if (ofs == (ADDR_W-1)'(OFS_AR)) begin
            bus_rdata = ar_q;
        end
    end
endmodule

// File: rtl/flc_checker.sv
module flc_checker
    import flc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic        flash_we,
    input logic        key_we,
    input logic        cr_we,
    input logic        sr_we,
    input logic        unlocked,
    input logic        busy,
    input logic        done,
    input logic        strt,
    input logic        eop
);
    // R2: unlocking only follows the second key word
    a_r2_unlock_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(key_we && bus_wdata == KEY_SECOND));

    // R4: a locked flash write never starts an operation
    a_r4_locked_no_start: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !busy && flash_we) |=> !busy);

    // R5: relock bit closes the controller
    a_r5_relock: assert property (@(posedge clk) disable iff (rst)
        (cr_we && bus_wdata[CB_LOCK]) |=> !unlocked);

    // R6: busy starts only from a bus write
    a_r6_busy_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_we));

    // R8: start bit is clear once busy falls
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !strt);

    // R12: write-one clears end of operation
    a_r12_eop_w1c: assert property (@(posedge clk) disable iff (rst)
        (sr_we && bus_wdata[SB_EOP] && !done) |=> !eop);
endmodule

bind flash_ctl flc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .flash_we  (bus_we && is_flash),
    .key_we    (key_we),
    .cr_we     (cr_we),
    .sr_we     (sr_we),
    .unlocked  (unlocked),
    .busy      (busy),
    .done      (op_done),
    .strt      (ctrl_q.strt),
    .eop       (eop_q)
);

// File: tb/sim_flash_ctl.sv
module sim_flash_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int AB   = 256;
    localparam int PB   = 64;
    localparam int PC   = 5;
    localparam int EC   = 12;
    localparam int NHW  = AB / 2;
    localparam int PHW  = PB / 2;
    localparam logic [3:0] WP = 4'b0100;
    localparam int AW   = 9;

    localparam logic [31:0] K1 = 32'h4567_0123;
    localparam logic [31:0] K2 = 32'hCDEF_89AB;
    localparam logic [AW-1:0] A_KEY = 9'h004, A_OKEY = 9'h008, A_SR = 9'h00C,
                              A_CR = 9'h010, A_AR = 9'h014;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [15:0] model [NHW];

    flash_ctl #(
        .ARRAY_BYTES (AB),
        .PAGE_BYTES  (PB),
        .PROG_CYCLES (PC),
        .ERASE_CYCLES(EC),
        .WP_MASK     (WP)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] fa(input int hw);
        return 9'h100 | AW'(hw * 2);
    endfunction

    function automatic bit protected_hw(input int hw);
        return WP[hw / PHW];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NHW; i++) model[i] = 16'hFFFF;
    endtask

    task automatic unlock();
        wr(A_KEY, K1);
        wr(A_KEY, K2);
    endtask

    task automatic sweep(input string req);
        logic [31:0] d;
        int bad = 0;
        for (int i = 0; i < NHW; i++) begin
            rd(fa(i), d);
            if (d[15:0] !== model[i]) bad++;
        end
        check(req, bad, 0);
    endtask

    // program one halfword and check its outcome against the bench model
    task automatic prog(input int hw, input logic [15:0] d, input string req);
        logic [31:0] s, r;
        logic [31:0] exp_sr;
        bit ok;
        wr(fa(hw), {16'h0, d});
        ok = 1'b0;
        if (protected_hw(hw))                             exp_sr = 32'h10;
        else if (model[hw] != 16'hFFFF && d != 16'h0000)  exp_sr = 32'h04;
        else begin exp_sr = 32'h01; ok = 1'b1; end
        rd(A_SR, s);
        check(req, s, exp_sr);
        if (ok) begin
            repeat (PC) @(negedge clk);
            rd(A_SR, s);
            check(req, s, 32'h20);
            model[hw] = d;
        end
        rd(fa(hw), r);
        check(req, r, {16'h0, model[hw]});
        wr(A_SR, 32'h34);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        do_reset();

        // R1 reset state
        rd(A_CR, d);   check("R1", d, 32'h80);
        rd(A_SR, d);   check("R1", d, 32'h0);
        rd(fa(0), d);  check("R1", d, 32'hFFFF);

        // R4 locked writes ignored
        wr(A_AR, 32'h40);  rd(A_AR, d); check("R4", d, 32'h0);
        wr(A_CR, 32'h1);   rd(A_CR, d); check("R4", d, 32'h80);
        wr(fa(3), 32'h0);  rd(A_SR, d); check("R4", d, 32'h0);
        rd(fa(3), d);      check("R4", d, 32'hFFFF);

        // R3 wrong key jams until reset
        wr(A_KEY, 32'h1234_5678);
        unlock();
        rd(A_CR, d); check("R3", d, 32'h80);
        do_reset();

        // R2 unlock
        unlock();
        rd(A_CR, d); check("R2", d, 32'h0);

        // R13 option write enable
        wr(A_CR, 32'h100);   rd(A_CR, d); check("R13", d, 32'h0);
        wr(A_OKEY, K1); wr(A_OKEY, K2);
        rd(A_CR, d); check("R13", d, 32'h100);
        wr(A_CR, 32'h0);     rd(A_CR, d); check("R13", d, 32'h0);

        // R6 program, R12 write-one-to-clear
        wr(A_CR, 32'h1);
        wr(fa(8), 32'hA5C3);
        rd(A_SR, d); check("R6", d, 32'h1);
        repeat (PC - 1) @(negedge clk);
        rd(A_SR, d); check("R6", d, 32'h1);
        @(negedge clk);
        rd(A_SR, d); check("R6", d, 32'h20);
        rd(fa(8), d); check("R6", d, 32'hA5C3);
        model[8] = 16'hA5C3;
        wr(A_SR, 32'h0);  rd(A_SR, d); check("R12", d, 32'h20);
        wr(A_SR, 32'h20); rd(A_SR, d); check("R12", d, 32'h0);

        // R7 reprogram error, zero overwrite allowed
        prog(8, 16'h1234, "R7");
        prog(8, 16'h0000, "R7");

        // R11 protected page program
        prog(2 * PHW + 1, 16'h5555, "R11");

        // random programming mixed across pages
        for (int k = 0; k < 40; k++) begin
            int hw;
            logic [15:0] v;
            hw = int'($urandom % NHW);
            v  = (($urandom % 5) == 0) ? 16'h0 : 16'($urandom);
            prog(hw, v, "R7");
        end
        prog(PHW + 2, 16'h0F0F, "R6");
        prog(3 * PHW + 4, 16'h00F0, "R6");

        // R10 start without command
        wr(A_CR, 32'h0);
        wr(A_CR, 32'h40);
        rd(A_SR, d); check("R10", d, 32'h0);
        rd(A_CR, d); check("R10", d, 32'h0);

        // R8 page erase of page 1
        wr(A_CR, 32'h2);
        wr(A_AR, 32'h40);
        wr(A_CR, 32'h42);
        rd(A_SR, d); check("R8", d, 32'h1);
        rd(A_CR, d); check("R8", d, 32'h42);
        repeat (EC) @(negedge clk);
        rd(A_SR, d); check("R8", d, 32'h20);
        rd(A_CR, d); check("R8", d, 32'h2);
        for (int i = PHW; i < 2 * PHW; i++) model[i] = 16'hFFFF;
        sweep("R8");
        wr(A_SR, 32'h20);

        // R11 protected page erase
        wr(A_AR, 32'h80);
        wr(A_CR, 32'h42);
        rd(A_SR, d); check("R11", d, 32'h10);
        wr(A_SR, 32'h10);

        // R9 mass erase
        wr(A_CR, 32'h4);
        wr(A_CR, 32'h44);
        rd(A_SR, d); check("R9", d, 32'h1);
        repeat (EC) @(negedge clk);
        rd(A_SR, d); check("R9", d, 32'h20);
        for (int i = 0; i < NHW; i++) if (!protected_hw(i)) model[i] = 16'hFFFF;
        sweep("R9");
        wr(A_SR, 32'h20);

        // R5 relock and reopen
        wr(A_CR, 32'h80);  rd(A_CR, d); check("R5", d, 32'h80);
        wr(A_CR, 32'h1);   rd(A_CR, d); check("R5", d, 32'h80);
        unlock();
        rd(A_CR, d); check("R5", d, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule